// File: doc/BRIEF.md
# Pixel Hit Latency Buffer

This block terminates one column pair of a pixel readout. Each cycle of the crossing clock it may accept one sparse hit record: a pixel row, a column bit that selects the left or right column of the pair, and an 8-bit time-over-threshold (ToT) value. The block stamps each record with the crossing in which it arrived, taken from a free-running wrapping crossing counter. It then holds the record in a shared end-of-column store until the fixed trigger latency has elapsed.

A trigger input arrives one latency after the crossing it selects. When the oldest stored record reaches its latency age, the block looks up whether its crossing was triggered. A triggered record is presented on a valid/ready output stream and held there under backpressure. A record whose crossing was not triggered is freed silently. To recover hits that cross threshold late, a record whose ToT is at or below a programmable limit is stored twice: once with its own crossing and once with the previous crossing. When the store lacks room for all copies of a record, the whole record is dropped. The block then raises a sticky overflow flag and bumps a saturating drop counter.

Top module: `pxl_latency_buf`

## Requirements
- R1: After reset, out_valid is 0, ovf_flag is 0 and ovf_count is 0.
- R2: The crossing counter is 0 during reset and advances by one on every clock edge with rst_n high. A record accepted on the edge where the counter holds t is tagged with timestamp t mod 2^TS_W, and that tag appears on out_ts.
- R3: A stored entry with timestamp s is never presented before the crossing counter reaches s + LATENCY. With an empty path ahead and out_ready high, it is presented exactly in that crossing.
- R4: trig high in the crossing where the counter holds b marks crossing b − LATENCY as triggered. Entries of triggered crossings leave the output in timestamp order, each once, with the row, column, ToT and timestamp they were stored with.
- R5: An entry whose crossing was not triggered is freed without ever asserting out_valid, and it does not delay later entries.
- R6: A record with hit_tot <= dup_limit (unsigned) also stores a copy tagged t − 1. That copy lies ahead of the primary entry and carries the same row, column and ToT. A record with hit_tot > dup_limit stores only the primary entry.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_row, out_col, out_tot and out_ts stay unchanged on the next cycle.
- R8: A record is accepted only if the free space in the store, counted before any pop of that cycle, covers all of its copies (1 or 2). Otherwise it is dropped whole, ovf_count rises by exactly one and ovf_flag is set. A load the store can sustain causes no drop.
- R9: ovf_count saturates at 2^OVF_W − 1. ovf_flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_valid | input | 1 | A hit record is offered this crossing |
| hit_row | input | ROW_W | Pixel row of the hit |
| hit_col | input | COL_W | Column within the column pair |
| hit_tot | input | 8 | Time-over-threshold of the hit |
| dup_limit | input | 8 | ToT at or below which the hit is also stored one crossing earlier |
| trig | input | 1 | Trigger for the crossing LATENCY crossings ago |
| out_valid | output | 1 | A triggered entry is presented |
| out_ready | input | 1 | Downstream accepts the presented entry |
| out_row | output | ROW_W | Row of the presented entry |
| out_col | output | COL_W | Column of the presented entry |
| out_tot | output | 8 | ToT of the presented entry |
| out_ts | output | TS_W | Crossing timestamp of the presented entry |
| ovf_flag | output | 1 | Sticky: at least one record was dropped |
| ovf_count | output | OVF_W | Saturating count of dropped records |

## Verification
A corrupted entry in the store shows up on the stream as a wrong row, column, ToT or timestamp. This happens in the very crossing that entry's latency expires, so any error surfaces within LATENCY crossings of the write. A wrong read or write pointer, or a stale trigger mark, shows up as an extra, missing or reordered record at the next head expiry. An occupancy count that drifts shows up as a drop that should not happen under a sustainable load, or as an accepted record when the store is full. Either one moves ovf_count on the very next edge.

// File: rtl/pxl_lat_pkg.sv
// Shared definitions for the pixel hit latency buffer.
package pxl_lat_pkg;
    // Width of the time-over-threshold field carried by every record.
    localparam int TOT_W = 8;

    // What the oldest stored entry does this crossing.
    typedef enum logic [1:0] {
        HD_EMPTY = 2'd0,   // nothing stored
        HD_AGING = 2'd1,   // head still inside its latency window
        HD_SEND  = 2'd2,   // head expired and its crossing was triggered
        HD_DROP  = 2'd3    // head expired without a trigger: free it
    } head_state_e;
endpackage

// File: rtl/pxl_hit_fifo.sv
// Circular store for timestamped hit entries with two write ports.
// Port A is written ahead of port B in the same cycle, so a duplicated
// record keeps its earlier copy in front. Assumes DEPTH is a power of two,
// at least 2, and that the caller never writes more entries than are free.
module pxl_hit_fifo #(
    parameter int W     = 25,
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_a,
    input  logic [W-1:0]               data_a,
    input  logic                       push_b,
    input  logic [W-1:0]               data_b,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] slot_b;
    logic          pop_ok;

    assign slot_b = wr_ptr + AW'(push_a);
    assign pop_ok = pop && (count != '0);
    assign head   = mem[rd_ptr];

    // Storage write: A lands first, B in the following slot.
    always_ff @(posedge clk) begin
        if (push_a) mem[wr_ptr] <= data_a;
        if (push_b) mem[slot_b] <= data_b;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(push_a) + AW'(push_b);
            rd_ptr <= rd_ptr + AW'(pop_ok);
            count  <= count + CW'(push_a) + CW'(push_b) - CW'(pop_ok);
        end
    end
endmodule

// File: rtl/pxl_trig_hist.sv
// One trigger mark per timestamp value. Each crossing writes the trigger
// bit of the crossing that is LATENCY old. Reads of the slot being written
// this cycle see the incoming bit. Assumes no entry waits longer than one
// full timestamp wrap.
module pxl_trig_hist #(
    parameter int TS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] wr_idx,
    input  logic            wr_bit,
    input  logic [TS_W-1:0] rd_idx,
    output logic            rd_bit
);
    localparam int N = 1 << TS_W;

    logic [N-1:0] marks;

    // Record the trigger decision for the crossing leaving the window.
    always_ff @(posedge clk) begin
        if (!rst_n) marks <= '0;
        else        marks[wr_idx] <= wr_bit;
    end

    // Lookup with same-cycle bypass.
    always_comb begin
        if (rd_idx == wr_idx) rd_bit = wr_bit;
        else                  rd_bit = marks[rd_idx];
    end
endmodule

// File: rtl/pxl_ovf_track.sv
// Counts dropped records with saturation and keeps a sticky flag.
// Assumes drop is a one-cycle pulse per dropped record.
module pxl_ovf_track #(
    parameter int OVF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drop,
    output logic             flag,
    output logic [OVF_W-1:0] count
);
    localparam logic [OVF_W-1:0] CMAX = '1;

    // Saturating drop counter and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            flag  <= 1'b0;
        end else if (drop) begin
            flag <= 1'b1;
            if (count != CMAX) count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/pxl_latency_buf.sv
// End-of-column latency buffer for one pixel column pair.
// It tags each accepted hit with the current crossing and duplicates
// low-ToT hits one crossing back. Entries are held until LATENCY crossings
// have passed. The oldest entry is then sent if its crossing was triggered
// and freed otherwise. Assumes LATENCY < 2^TS_W, DEPTH a power of two, and a
// sink that never stalls the head beyond 2^TS_W - LATENCY crossings.
module pxl_latency_buf
    import pxl_lat_pkg::*;
#(
    parameter int ROW_W   = 8,
    parameter int COL_W   = 1,
    parameter int TS_W    = 8,
    parameter int LATENCY = 100,
    parameter int DEPTH   = 64,
    parameter int OVF_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_valid,
    input  logic [ROW_W-1:0] hit_row,
    input  logic [COL_W-1:0] hit_col,
    input  logic [TOT_W-1:0] hit_tot,
    input  logic [TOT_W-1:0] dup_limit,
    input  logic             trig,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [ROW_W-1:0] out_row,
    output logic [COL_W-1:0] out_col,
    output logic [TOT_W-1:0] out_tot,
    output logic [TS_W-1:0]  out_ts,
    output logic             ovf_flag,
    output logic [OVF_W-1:0] ovf_count
);
    localparam int              ENT_W  = ROW_W + COL_W + TOT_W + TS_W;
    localparam int              CNT_W  = $clog2(DEPTH+1);
    localparam logic [TS_W-1:0] LAT_TS = TS_W'(LATENCY);

    logic [TS_W-1:0]  bx_cnt;
    logic [TS_W-1:0]  ts_prev;
    logic             wants_dup;
    logic [CNT_W-1:0] need;
    logic [CNT_W-1:0] room;
    logic [CNT_W-1:0] fifo_count;
    logic             accept;
    logic             drop;
    logic [ENT_W-1:0] ent_dup;
    logic [ENT_W-1:0] ent_prim;
    logic [ENT_W-1:0] fifo_head;
    logic [ROW_W-1:0] head_row;
    logic [COL_W-1:0] head_col;
    logic [TOT_W-1:0] head_tot;
    logic [TS_W-1:0]  head_ts;
    logic [TS_W-1:0]  head_age;
    logic [TS_W-1:0]  hist_wr_idx;
    logic             head_trig;
    logic             pop;
    head_state_e      head_state;

    // Free-running crossing counter, the timestamp source.
    always_ff @(posedge clk) begin
        if (!rst_n) bx_cnt <= '0;
        else        bx_cnt <= bx_cnt + 1'b1;
    end

    // Admission: a record goes in whole or not at all.
    always_comb begin
        wants_dup = (hit_tot <= dup_limit);
        need      = wants_dup ? CNT_W'(2) : CNT_W'(1);
        room      = CNT_W'(DEPTH) - fifo_count;
        accept    = hit_valid && (need <= room);
        drop      = hit_valid && !accept;
        ts_prev   = bx_cnt - TS_W'(1);
        ent_dup   = {hit_row, hit_col, hit_tot, ts_prev};
        ent_prim  = {hit_row, hit_col, hit_tot, bx_cnt};
    end

    pxl_hit_fifo #(
        .W     (ENT_W),
        .DEPTH (DEPTH)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_a (accept && wants_dup),
        .data_a (ent_dup),
        .push_b (accept),
        .data_b (ent_prim),
        .pop    (pop),
        .head   (fifo_head),
        .count  (fifo_count)
    );

    assign {head_row, head_col, head_tot, head_ts} = fifo_head;
    assign head_age    = bx_cnt - head_ts;
    assign hist_wr_idx = bx_cnt - LAT_TS;

    pxl_trig_hist #(
        .TS_W (TS_W)
    ) u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_idx (hist_wr_idx),
        .wr_bit (trig),
        .rd_idx (head_ts),
        .rd_bit (head_trig)
    );

    // Decide what the oldest entry does this crossing.
    always_comb begin
        if (fifo_count == '0)       head_state = HD_EMPTY;
        else if (head_age < LAT_TS) head_state = HD_AGING;
        else if (head_trig)         head_state = HD_SEND;
        else                        head_state = HD_DROP;
    end

    assign out_valid = (head_state == HD_SEND);
    assign pop       = (head_state == HD_DROP) || (out_valid && out_ready);
    assign out_row   = head_row;
    assign out_col   = head_col;
    assign out_tot   = head_tot;
    assign out_ts    = head_ts;

    pxl_ovf_track #(
        .OVF_W (OVF_W)
    ) u_ovf (
        .clk   (clk),
        .rst_n (rst_n),
        .drop  (drop),
        .flag  (ovf_flag),
        .count (ovf_count)
    );
endmodule

// File: rtl/pxl_latency_buf_chk.sv
// Property checker for the pixel hit latency buffer, bound to the top.
module pxl_latency_buf_chk #(
    parameter int ROW_W   = 8,
    parameter int COL_W   = 1,
    parameter int TS_W    = 8,
    parameter int LATENCY = 100,
    parameter int OVF_W   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic             out_ready,
    input logic [ROW_W-1:0] out_row,
    input logic [COL_W-1:0] out_col,
    input logic [7:0]       out_tot,
    input logic [TS_W-1:0]  out_ts,
    input logic             ovf_flag,
    input logic [OVF_W-1:0] ovf_count,
    input logic [TS_W-1:0]  bx_cnt
);
    logic [TS_W-1:0] shown_age;
    assign shown_age = bx_cnt - out_ts;

    // R1: the cycle after reset is held, the outputs are in their idle state.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !ovf_flag && ovf_count == '0));

    // R3: nothing is shown before its latency has elapsed.
    a_r3_min_age: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (shown_age >= TS_W'(LATENCY)));

    // R7: a stalled output holds.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_row) &&
            $stable(out_col) && $stable(out_tot) && $stable(out_ts)));

    // R8: a nonzero drop count implies the flag.
    a_r8_flag_with_count: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_count != '0) |-> ovf_flag);

    // R9: the flag never clears outside reset.
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    // R9: the counter only holds or steps up by one.
    a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ovf_count == $past(ovf_count) ||
                  ovf_count == $past(ovf_count) + 1'b1));
endmodule

bind pxl_latency_buf pxl_latency_buf_chk #(
    .ROW_W   (ROW_W),
    .COL_W   (COL_W),
    .TS_W    (TS_W),
    .LATENCY (LATENCY),
    .OVF_W   (OVF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_row   (out_row),
    .out_col   (out_col),
    .out_tot   (out_tot),
    .out_ts    (out_ts),
    .ovf_flag  (ovf_flag),
    .ovf_count (ovf_count),
    .bx_cnt    (bx_cnt)
);

// File: tb/pxl_latency_buf_bench.sv
// Self-checking bench: directed latency/duplication cases, full ToT sweeps
// under three duplication limits with backpressure, and an overflow run.
module pxl_latency_buf_bench;
    localparam int ROW_W = 4;
    localparam int COL_W = 1;
    localparam int TS_W  = 6;
    localparam int LAT   = 12;
    localparam int DEPTH = 16;
    localparam int OVF_W = 3;
    localparam int ENT_W = ROW_W + COL_W + 8 + TS_W;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             hit_valid;
    logic [ROW_W-1:0] hit_row;
    logic [COL_W-1:0] hit_col;
    logic [7:0]       hit_tot;
    logic [7:0]       dup_limit;
    logic             trig;
    logic             out_valid;
    logic             out_ready;
    logic [ROW_W-1:0] out_row;
    logic [COL_W-1:0] out_col;
    logic [7:0]       out_tot;
    logic [TS_W-1:0]  out_ts;
    logic             ovf_flag;
    logic [OVF_W-1:0] ovf_count;

    pxl_latency_buf #(
        .ROW_W   (ROW_W),
        .COL_W   (COL_W),
        .TS_W    (TS_W),
        .LATENCY (LAT),
        .DEPTH   (DEPTH),
        .OVF_W   (OVF_W)
    ) u_pxl_latency_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_valid (hit_valid),
        .hit_row   (hit_row),
        .hit_col   (hit_col),
        .hit_tot   (hit_tot),
        .dup_limit (dup_limit),
        .trig      (trig),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_row   (out_row),
        .out_col   (out_col),
        .out_tot   (out_tot),
        .out_ts    (out_ts),
        .ovf_flag  (ovf_flag),
        .ovf_count (ovf_count)
    );

    always #2 clk = ~clk;

    int checks   = 0;
    int errors   = 0;
    int abs_bx   = 0;
    int ovf_lo   = -1000;
    int ovf_hi   = -1000;
    int rdy_mode = 0;
    int n_out    = 0;
    int n_exp    = 0;
    bit finished = 1'b0;
    logic [ENT_W-1:0] exp_q [$];
    logic [ENT_W-1:0] cur;
    logic [ENT_W-1:0] held_e;
    logic             held_v = 1'b0;

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Trigger decision per absolute crossing (forced high in the overflow window).
    function automatic bit trig_pat(input int c);
        if (c >= ovf_lo && c <= ovf_hi) return 1'b1;
        if (c < 1) return 1'b0;
        return ((c * 5 + 3) % 7) < 4;
    endfunction

    // Crossing model and trigger/ready drivers, applied 1 ns after the edge.
    always @(posedge clk) begin
        if (rst_n) abs_bx = abs_bx + 1;
        else       abs_bx = 0;
        #1;
        trig = (abs_bx >= LAT) ? trig_pat(abs_bx - LAT) : 1'b0;
        if (rdy_mode == 0)      out_ready = 1'b1;
        else if (rdy_mode == 1) out_ready = ((abs_bx % 4) != 1);
        else                    out_ready = 1'b0;
    end

    // Scoreboard and hold monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            cur = {out_row, out_col, out_tot, out_ts};
            if (held_v) check(out_valid && cur == held_e, "R7", {out_valid, cur}, {1'b1, held_e});
            held_v = out_valid && !out_ready;
            held_e = cur;
            if (out_valid && out_ready) begin
                n_out++;
                if (exp_q.size() == 0) check(1'b0, "R5", cur, 0);
                else begin
                    check(cur == exp_q[0], "R4", cur, exp_q[0]);
                    void'(exp_q.pop_front());
                end
            end
        end else held_v = 1'b0;
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_bx(input int n);
        while (abs_bx < n) step();
        @(negedge clk);
    endtask

    // Offer one record this crossing; take = the store is expected to accept it.
    task automatic send(input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c,
                        input logic [7:0] v, input bit take);
        int t;
        t = abs_bx;
        hit_valid = 1'b1;
        hit_row   = r;
        hit_col   = c;
        hit_tot   = v;
        if (take) begin
            if (v <= dup_limit && trig_pat(t - 1)) begin
                exp_q.push_back({r, c, v, TS_W'(t - 1)});
                n_exp++;
            end
            if (trig_pat(t)) begin
                exp_q.push_back({r, c, v, TS_W'(t)});
                n_exp++;
            end
        end
        step();
        hit_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) step();
        repeat (LAT + 4) step();
    endtask

    initial begin
        int t;
        int lims [3] = '{10, 0, 255};
        rst_n = 1'b0; hit_valid = 1'b0; hit_row = '0; hit_col = '0;
        hit_tot = '0; dup_limit = 8'd10; trig = 1'b0; out_ready = 1'b1;
        repeat (3) step();
        check(!out_valid && !ovf_flag && ovf_count == 0, "R1",
              {out_valid, ovf_flag, ovf_count}, 0);
        rst_n = 1'b1;
        repeat (3) step();

        // R2 / R3: single triggered record appears exactly at t+LAT.
        while (!trig_pat(abs_bx)) step();
        t = abs_bx;
        send(4'h3, 1'b1, 8'd100, 1'b1);
        wait_bx(t + LAT - 1);
        check(!out_valid, "R3", out_valid, 0);
        wait_bx(t + LAT);
        check(out_valid, "R3", out_valid, 1);
        check(out_ts == TS_W'(t) && out_tot == 8'd100 && out_row == 4'h3,
              "R2", {out_row, out_tot, out_ts}, {4'h3, 8'd100, TS_W'(t)});
        drain();

        // R6: ToT equal to the limit is stored one crossing back as well.
        while (!(trig_pat(abs_bx - 1) && trig_pat(abs_bx))) step();
        t = abs_bx;
        send(4'h5, 1'b0, 8'd10, 1'b1);
        wait_bx(t + LAT - 2);
        check(!out_valid, "R3", out_valid, 0);
        wait_bx(t + LAT - 1);
        check(out_valid && out_ts == TS_W'(t - 1) && out_tot == 8'd10, "R6",
              {out_valid, out_ts}, {1'b1, TS_W'(t - 1)});
        wait_bx(t + LAT);
        check(out_valid && out_ts == TS_W'(t), "R6", {out_valid, out_ts}, {1'b1, TS_W'(t)});
        drain();

        // R6: ToT one above the limit is stored once.
        while (!(trig_pat(abs_bx - 1) && trig_pat(abs_bx))) step();
        t = abs_bx;
        send(4'h9, 1'b1, 8'd11, 1'b1);
        wait_bx(t + LAT - 1);
        check(!out_valid, "R6", out_valid, 0);
        wait_bx(t + LAT);
        check(out_valid && out_ts == TS_W'(t), "R6", {out_valid, out_ts}, {1'b1, TS_W'(t)});
        drain();

        // R5: untriggered record is freed and does not block the next one.
        while (trig_pat(abs_bx)) step();
        t = abs_bx;
        send(4'h6, 1'b1, 8'd50, 1'b1);
        wait_bx(t + LAT);
        check(!out_valid, "R5", out_valid, 0);
        wait_bx(t + LAT + 1);
        check(!out_valid, "R5", out_valid, 0);
        while (!trig_pat(abs_bx)) step();
        t = abs_bx;
        send(4'h7, 1'b0, 8'd60, 1'b1);
        wait_bx(t + LAT);
        check(out_valid && out_ts == TS_W'(t) && out_row == 4'h7, "R5",
              {out_valid, out_row, out_ts}, {1'b1, 4'h7, TS_W'(t)});
        drain();

        // R4 / R6 / R7: full ToT sweep for three limits under backpressure.
        rdy_mode = 1;
        for (int k = 0; k < 3; k++) begin
            dup_limit = 8'(lims[k]);
            for (int v = 0; v < 256; v++) begin
                send(ROW_W'(v) ^ 4'h5, COL_W'(v >> 4), 8'(v), 1'b1);
                repeat (3) step();
            end
            drain();
        end
        check(ovf_count == 0 && !ovf_flag, "R8", {ovf_flag, ovf_count}, 0);
        check(n_out == n_exp, "R4", n_out, n_exp);

        // R8 / R9: fill with the sink stalled, then overflow.
        rdy_mode = 2;
        dup_limit = 8'd10;
        ovf_lo = abs_bx - 1;
        ovf_hi = abs_bx + 60;
        for (int i = 0; i < 15; i++) send(ROW_W'(i), 1'b0, 8'd200, 1'b1);
        send(4'h1, 1'b1, 8'd3, 1'b0);
        check(ovf_count == 1 && ovf_flag, "R8", {ovf_flag, ovf_count}, {1'b1, 3'd1});
        send(4'h2, 1'b1, 8'd200, 1'b1);
        check(ovf_count == 1, "R8", ovf_count, 1);
        for (int i = 0; i < 8; i++) send(4'h3, 1'b0, 8'd200, 1'b0);
        check(ovf_count == 7 && ovf_flag, "R9", {ovf_flag, ovf_count}, {1'b1, 3'd7});
        @(negedge clk);
        check(out_valid, "R7", out_valid, 1);
        rdy_mode = 0;
        drain();
        check(ovf_count == 7 && ovf_flag, "R9", {ovf_flag, ovf_count}, {1'b1, 3'd7});
        check(n_out == n_exp, "R8", n_out, n_exp);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", abs_bx, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule